// File: doc/BRIEF.md
# 8-bit ALU with Condition Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It is purely combinational. On every evaluation it takes an accumulator operand, a memory operand, an operation code and the current six-bit flag register. It returns three things: the 8-bit result, a write-back enable that tells the register file whether to store that result, and the next value of the flag register.

Every operation has its own rule for each flag. Only the add-type operations update the half carry. Shifts and rotates derive overflow from the new sign and the new carry. Decimal adjust can set carry but never clears it. Any flag an operation does not name keeps its incoming value. The interrupt mask bit always passes through unchanged. Instruction decode, operand fetch and timing are left to the surrounding sequencer.

Top module: `alu8_core`

## Requirements
- R1: The flag word places H at bit 5, I at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. I always passes through unchanged. H changes only for ADD and ADC and keeps its input value for every other operation.
- R2: ADD computes A+M and ADC computes A+M+C. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands have the same sign and the result sign differs from it.
- R3: SUB computes A−M, SBC computes A−M−C and CMP computes A−M. C is the borrow. V is set when the operand signs differ and the result sign differs from the sign of A. CMP does not write back.
- R4: AND, BIT, OR, XOR and PASS (PASS forwards M, as used by load, store and transfer) set V to 0 and keep C. BIT forms A AND M without writing back.
- R5: CLR returns 0x00 with N=0, Z=1, V=0 and C=0.
- R6: COM returns the bitwise inverse of A, forces C to 1 and clears V.
- R7: NEG returns 0x00−A. V is set only when the result is 0x80. C is set exactly when the result is nonzero.
- R8: INC returns A+1 and sets V only for A=0x7F. DEC returns A−1 and sets V only for A=0x80. Both keep C.
- R9: ASL, ASR, LSR, ROL and ROR act on A. C receives the bit shifted out: bit 7 for left moves, bit 0 for right moves. ASL and LSR shift in 0, ASR copies bit 7, and ROL and ROR shift in the old C. After the shift, V equals N XOR C. LSR always yields N=0.
- R10: TST examines A without writing back and clears V and C.
- R11: DAA adds 0x06 when A's low nibble exceeds 9 or H is set. It adds 0x60 when the high nibble exceeds 9, when C is set, or when the high nibble exceeds 8 and the low nibble exceeds 9. V is kept.
- R12: DAA sets C when the 0x60 correction is applied and never clears a C that was already set.
- R13: Write-back enable is 1 for every operation except CMP, BIT and TST.
- R14: For every operation, N equals bit 7 of the result and Z is 1 exactly when the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code, an alu_op_e value from the package |
| opa | input | 8 | Accumulator operand |
| opm | input | 8 | Memory or second operand |
| flags_in | input | 6 | Current flags {H,I,N,Z,V,C} |
| result | output | 8 | Computed result |
| wr_en | output | 1 | Result should be written back |
| flags_out | output | 6 | Next flags {H,I,N,Z,V,C} |

## Verification
Embedded assertions check, on every evaluation, the following invariants:

- H is preserved by all non-add operations, and I passes through.
- Shift and rotate overflow equals N XOR C.
- NEG carry reflects a nonzero result.
- CLR yields zero.
- Increment and decrement leave carry alone.
- Decimal adjust never drops a set carry.

The actual arithmetic values cannot be checked that way: sums, borrows, signed-overflow cases, the decimal correction amounts and the write-back enable pattern. Those appear only in the bench scenarios. These include a table of directed vectors, an exhaustive increment sweep, a nibble-level half-carry sweep and a sweep over all operations for H preservation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 5;
    localparam int FW  = 6;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_BIT  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_CLR  = 5'd9,
        OP_COM  = 5'd10,
        OP_NEG  = 5'd11,
        OP_INC  = 5'd12,
        OP_DEC  = 5'd13,
        OP_ASL  = 5'd14,
        OP_ASR  = 5'd15,
        OP_LSR  = 5'd16,
        OP_ROL  = 5'd17,
        OP_ROR  = 5'd18,
        OP_TST  = 5'd19,
        OP_DAA  = 5'd20,
        OP_PASS = 5'd21
    } alu_op_e;

    // Bit order matches the flag register: H is bit 5, C is bit 0.
    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic is_add_type(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC);
    endfunction

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_ASL) || (op == OP_ASR) || (op == OP_LSR) ||
               (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic writes_back(alu_op_e op);
        return (op <= OP_PASS) && (op != OP_CMP) && (op != OP_BIT) && (op != OP_TST);
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W-1:0]  b_eff;
    logic          ci;
    logic [W:0]    full;
    logic [HW:0]   low;

    always_comb begin
        b_eff = sub ? ~b : b;
        ci    = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
        low   = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, ci};
        sum   = full[W-1:0];
        carry = full[W];
        half  = low[HW];
        ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        res  = a;
        cout = cin;
        unique case (op)
            OP_ASL: begin res = {a[DW-2:0], 1'b0};  cout = a[DW-1]; end
            OP_ROL: begin res = {a[DW-2:0], cin};   cout = a[DW-1]; end
            OP_ASR: begin res = {a[DW-1], a[DW-1:1]}; cout = a[0]; end
            OP_LSR: begin res = {1'b0, a[DW-1:1]};  cout = a[0];    end
            OP_ROR: begin res = {cin, a[DW-1:1]};   cout = a[0];    end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          h,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic [NIB-1:0] lo_dig, hi_dig;
    logic           fix_lo, fix_hi;

    always_comb begin
        lo_dig = a[NIB-1:0];
        hi_dig = a[DW-1:NIB];
        fix_lo = (lo_dig > NIB'(9)) || h;
        fix_hi = (hi_dig > NIB'(9)) || cin || ((hi_dig > NIB'(8)) && (lo_dig > NIB'(9)));
        res    = a + {(fix_hi ? NIB'(6) : NIB'(0)), (fix_lo ? NIB'(6) : NIB'(0))};
        cout   = cin | fix_hi;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opm,
    input  logic [FW-1:0]  flags_in,
    output logic [DW-1:0]  result,
    output logic           wr_en,
    output logic [FW-1:0]  flags_out
);
    alu_op_e       op;
    flags_t        fi, fo;
    logic [DW-1:0] as_a, as_b, as_sum, sh_res, da_res, res;
    logic          as_sub, as_cin, as_carry, as_half, as_ovf;
    logic          sh_c, da_c;

    assign op = alu_op_e'(op_sel);
    assign fi = flags_t'(flags_in);

    // Operand steering for the shared adder/subtractor.
    always_comb begin
        as_a   = opa;
        as_b   = opm;
        as_sub = 1'b0;
        as_cin = 1'b0;
        case (op)
            OP_ADC:         as_cin = fi.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC:         begin as_sub = 1'b1; as_cin = fi.c; end
            OP_NEG:         begin as_a = '0; as_b = opa; as_sub = 1'b1; end
            OP_INC:         as_b = DW'(1);
            OP_DEC:         begin as_b = DW'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DW)) u_addsub (
        .a(as_a), .b(as_b), .sub(as_sub), .cin(as_cin),
        .sum(as_sum), .carry(as_carry), .half(as_half), .ovf(as_ovf)
    );

    alu8_shifter u_shift (.op(op), .a(opa), .cin(fi.c), .res(sh_res), .cout(sh_c));

    alu8_decadj u_daa (.a(opa), .h(fi.h), .cin(fi.c), .res(da_res), .cout(da_c));

    // Per-operation flag policy; untouched flags keep their input value.
    always_comb begin
        fo  = fi;
        res = opa;
        case (op)
            OP_ADD, OP_ADC: begin
                res = as_sum; fo.h = as_half; fo.c = as_carry; fo.v = as_ovf;
            end
            OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                res = as_sum; fo.c = ~as_carry; fo.v = as_ovf;
            end
            OP_INC, OP_DEC: begin res = as_sum; fo.v = as_ovf; end
            OP_AND, OP_BIT: begin res = opa & opm; fo.v = 1'b0; end
            OP_OR:          begin res = opa | opm; fo.v = 1'b0; end
            OP_XOR:         begin res = opa ^ opm; fo.v = 1'b0; end
            OP_PASS:        begin res = opm;       fo.v = 1'b0; end
            OP_CLR:         begin res = '0; fo.v = 1'b0; fo.c = 1'b0; end
            OP_COM:         begin res = ~opa; fo.v = 1'b0; fo.c = 1'b1; end
            OP_TST:         begin res = opa; fo.v = 1'b0; fo.c = 1'b0; end
            OP_DAA:         begin res = da_res; fo.c = da_c; end
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                res = sh_res; fo.c = sh_c; fo.v = sh_res[DW-1] ^ sh_c;
            end
            default: ;
        endcase
        fo.n = res[DW-1];
        fo.z = (res == '0);
    end

    assign result    = res;
    assign flags_out = fo;
    assign wr_en     = writes_back(op);

    // Invariants checked against the outputs on every evaluation.
    always_comb begin
        if (!is_add_type(op))
            assert_h_kept_R1: assert (flags_out[5] == flags_in[5]);
        assert_i_pass_R1: assert (flags_out[4] == flags_in[4]);
        if (is_shift(op))
            assert_shift_v_R9: assert (flags_out[1] == (flags_out[3] ^ flags_out[0]));
        if (op == OP_NEG)
            assert_neg_carry_R7: assert (flags_out[0] == (result != '0));
        if (op == OP_CLR)
            assert_clr_zero_R5: assert (result == '0 && flags_out[0] == 1'b0);
        if (op == OP_INC || op == OP_DEC)
            assert_incdec_c_R8: assert (flags_out[0] == flags_in[0]);
        if (op == OP_DAA && flags_in[0])
            assert_daa_sticky_R12: assert (flags_out[0]);
    end
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    import alu8_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [OPW-1:0] op_sel = '0;
    logic [DW-1:0]  opa = '0, opm = '0, result;
    logic [FW-1:0]  flags_in = '0, flags_out;
    logic           wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    alu8_core dut (
        .op_sel(op_sel), .opa(opa), .opm(opm), .flags_in(flags_in),
        .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    // {op, a, m, flags_in, exp_result, exp_wr, exp_flags}
    localparam int NV = 30;
    localparam logic [41:0] VEC [NV] = '{
        {5'(OP_ADD), 8'h3A, 8'h48, 6'h00, 8'h82, 1'b1, 6'h2A}, // R2 half carry, overflow
        {5'(OP_ADD), 8'hFF, 8'h01, 6'h00, 8'h00, 1'b1, 6'h25}, // R2 carry, zero
        {5'(OP_ADC), 8'h10, 8'h20, 6'h01, 8'h31, 1'b1, 6'h00}, // R2 carry in
        {5'(OP_SUB), 8'h05, 8'h07, 6'h20, 8'hFE, 1'b1, 6'h29}, // R3 borrow, H kept
        {5'(OP_SBC), 8'h80, 8'h00, 6'h01, 8'h7F, 1'b1, 6'h02}, // R3 overflow
        {5'(OP_CMP), 8'h42, 8'h42, 6'h00, 8'h00, 1'b0, 6'h04}, // R3 R13 no write
        {5'(OP_AND), 8'hF0, 8'h3C, 6'h03, 8'h30, 1'b1, 6'h01}, // R4 C kept
        {5'(OP_BIT), 8'h80, 8'h80, 6'h00, 8'h80, 1'b0, 6'h08}, // R4 R13
        {5'(OP_OR),  8'h00, 8'h00, 6'h12, 8'h00, 1'b1, 6'h14}, // R4 R1 I kept
        {5'(OP_XOR), 8'hAA, 8'h55, 6'h01, 8'hFF, 1'b1, 6'h09}, // R4
        {5'(OP_PASS),8'h11, 8'h9C, 6'h02, 8'h9C, 1'b1, 6'h08}, // R4 R14
        {5'(OP_CLR), 8'h5A, 8'h00, 6'h2B, 8'h00, 1'b1, 6'h24}, // R5
        {5'(OP_COM), 8'h0F, 8'h00, 6'h02, 8'hF0, 1'b1, 6'h09}, // R6
        {5'(OP_NEG), 8'h80, 8'h00, 6'h00, 8'h80, 1'b1, 6'h0B}, // R7
        {5'(OP_NEG), 8'h00, 8'h00, 6'h03, 8'h00, 1'b1, 6'h04}, // R7
        {5'(OP_NEG), 8'h01, 8'h00, 6'h00, 8'hFF, 1'b1, 6'h09}, // R7
        {5'(OP_INC), 8'h7F, 8'h00, 6'h01, 8'h80, 1'b1, 6'h0B}, // R8
        {5'(OP_DEC), 8'h80, 8'h00, 6'h00, 8'h7F, 1'b1, 6'h02}, // R8
        {5'(OP_INC), 8'hFF, 8'h00, 6'h00, 8'h00, 1'b1, 6'h04}, // R8 C kept
        {5'(OP_ASL), 8'h81, 8'h00, 6'h00, 8'h02, 1'b1, 6'h03}, // R9
        {5'(OP_ASR), 8'h81, 8'h00, 6'h00, 8'hC0, 1'b1, 6'h09}, // R9
        {5'(OP_LSR), 8'h01, 8'h00, 6'h00, 8'h00, 1'b1, 6'h07}, // R9
        {5'(OP_ROL), 8'h40, 8'h00, 6'h01, 8'h81, 1'b1, 6'h0A}, // R9
        {5'(OP_ROR), 8'h02, 8'h00, 6'h01, 8'h81, 1'b1, 6'h0A}, // R9
        {5'(OP_TST), 8'h00, 8'h00, 6'h03, 8'h00, 1'b0, 6'h04}, // R10
        {5'(OP_DAA), 8'h3C, 8'h00, 6'h00, 8'h42, 1'b1, 6'h00}, // R11 low fix
        {5'(OP_DAA), 8'h9A, 8'h00, 6'h00, 8'h00, 1'b1, 6'h05}, // R11 R12 both fixes
        {5'(OP_DAA), 8'h12, 8'h00, 6'h01, 8'h72, 1'b1, 6'h01}, // R12 sticky C
        {5'(OP_DAA), 8'h08, 8'h00, 6'h22, 8'h0E, 1'b1, 6'h22}, // R11 H fix, V kept
        {5'(OP_SUB), 8'h50, 8'hB0, 6'h00, 8'hA0, 1'b1, 6'h0B}  // R3 overflow with borrow
    };

    task automatic apply(input logic [4:0] o, input logic [7:0] a, input logic [7:0] m,
                         input logic [5:0] f);
        @(posedge clk);
        #1;
        op_sel = o; opa = a; opm = m; flags_in = f;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] er, input logic ew,
                         input logic [5:0] ef);
        n_checks++;
        if (result !== er || wr_en !== ew || flags_out !== ef) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h: got res=%h wr=%b fl=%h, expected res=%h wr=%b fl=%h",
                     req, op_sel, opa, result, wr_en, flags_out, er, ew, ef);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // Idle state: ADD of zeros gives zero with Z set (R14, R13).
        @(negedge clk);
        check("R14 idle", 8'h00, 1'b1, 6'h04);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][41:37], VEC[k][36:29], VEC[k][28:21], VEC[k][20:15]);
            check($sformatf("vector %0d", k), VEC[k][14:7], VEC[k][6], VEC[k][5:0]);
        end

        // R8: exhaustive increment with C clear.
        for (int a = 0; a < 256; a++) begin
            logic [7:0] r;
            r = 8'(a + 1);
            apply(5'(OP_INC), 8'(a), 8'h00, 6'h00);
            check("R8 inc sweep", r, 1'b1,
                  {1'b0, 1'b0, r[7], r == 8'h00, a == 8'h7F, 1'b0});
        end

        // R2: half carry from nibble sums.
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [7:0] a, m, r;
                logic [8:0] s;
                a = 8'(16 + x); m = 8'(32 + y);
                s = {1'b0, a} + {1'b0, m};
                r = s[7:0];
                apply(5'(OP_ADD), a, m, 6'h00);
                check("R2 half sweep", r, 1'b1,
                      {(x + y) > 15, 1'b0, r[7], r == 8'h00, 1'b0, 1'b0});
            end
        end

        // R1: H and I held by every operation that is not add-type.
        for (int o = 2; o <= 21; o++) begin
            apply(5'(o), 8'h3C, 8'h5A, 6'h30);
            n_checks++;
            if (flags_out[5:4] !== 2'b11) begin
                n_fail++;
                $display("FAIL R1 op=%0d: got H,I=%b, expected 11", o, flags_out[5:4]);
            end
        end

        // R13: write enable across all operations.
        for (int o = 0; o <= 21; o++) begin
            logic ew;
            ew = !(o == 4 || o == 6 || o == 19);
            apply(5'(o), 8'h01, 8'h02, 6'h00);
            n_checks++;
            if (wr_en !== ew) begin
                n_fail++;
                $display("FAIL R13 op=%0d: got wr=%b, expected %b", o, wr_en, ew);
            end
        end

        finish_run();
    end
endmodule